// File: doc/BRIEF.md
# Byte-Lane Parity Unit

The unit checks and generates parity on two data paths. Data is organised in nine-bit lanes. In each lane, bits 0 to 7 carry the payload and bit 8 carries the parity. The narrow path is 18 bits wide and holds two lanes. The wide path is 36 bits wide and holds four lanes. One odd/even select sets the parity sense for every check and every generated bit. With odd parity, a correct lane holds an odd number of ones. With even parity, it holds an even number.

On the narrow input bus, the unit checks every lane that the configured bus width uses. It drives an active-low error flag when any of those lanes is wrong. On the read side, each port has a generate enable. When that enable is high, the parity bit of every lane is replaced with a freshly computed value, and the payload is left as it is.

The narrow path has one set of lane XOR trees, and two users share it. The first user is the input checker. The second is the path that reads the mail word out through the narrow port. When a mail read asks for generated parity, the shared trees serve the mail word, so the error flag is held inactive for that cycle.

Every input is registered once. All outputs are derived from that register.

Top module: `lane_parity_unit`

## Requirements
- R1: While reset is high, the registered stage is cleared. After reset, `nar_perr_n` is 1 and `nar_rd_q` and `wide_rd_q` are zero.
- R2: Low lane check. If bits 8:0 of `nar_din` do not hold the parity selected by `odd_sel`, `nar_perr_n` is 0 one clock edge later. The exception is the forced case of R7.
- R3: `size_sel[0]` = 1 selects word width, and both narrow lanes (bits 8:0 and 17:9) are checked. `size_sel[0]` = 0 selects byte width. In byte width only bits 8:0 are checked, and a wrong upper lane leaves `nar_perr_n` at 1.
- R4: `odd_sel` = 1 selects odd parity and `odd_sel` = 0 selects even parity. The same setting applies to checking and to generation on both ports.
- R5: With `wide_gen_en` = 1, each bit 9k+8 of `wide_rd_q` carries the parity of bits 9k..9k+7, and the payload bits match `wide_fifo_q`. With `wide_gen_en` = 0, `wide_rd_q` equals `wide_fifo_q` unchanged.
- R6: When no mail read is selected, `nar_rd_q` is built from `nar_fifo_q`. With `nar_gen_en` = 1, its bits 8 and 17 are replaced with generated parity. With `nar_gen_en` = 0, it is passed through unchanged.
- R7: A mail read is selected when `nar_wr_en` = 0 and `size_sel` = 2'b11. If a mail read is selected and `nar_gen_en` = 1, then:
  - `nar_perr_n` is 1 whatever `nar_din` holds;
  - `nar_rd_q` is `mail_q` with generated parity in bits 8 and 17.
- R8: If a mail read is selected and `nar_gen_en` = 0, `nar_rd_q` is `mail_q` unchanged and the input check keeps reporting. With `nar_wr_en` = 1, `size_sel` = 2'b11 is an ordinary word width with no mail read.
- R9: Every output reflects the inputs presented before a rising clock edge, and it changes right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| odd_sel | input | 1 | 1 = odd parity, 0 = even parity |
| size_sel | input | 2 | Bit 0 selects word width; 2'b11 with write low selects the mail read |
| nar_wr_en | input | 1 | Narrow port write enable |
| nar_gen_en | input | 1 | Generate parity on narrow reads |
| wide_gen_en | input | 1 | Generate parity on wide reads |
| nar_din | input | 18 | Narrow input bus under check |
| nar_fifo_q | input | 18 | Queue data read toward the narrow port |
| mail_q | input | 18 | Mail word read toward the narrow port |
| wide_fifo_q | input | 36 | Queue data read toward the wide port |
| nar_perr_n | output | 1 | Narrow input parity error, active low |
| nar_rd_q | output | 18 | Narrow read data |
| wide_rd_q | output | 36 | Wide read data |

## Verification
Each result of the block is due one rising edge after its stimulus. This holds for the error flag, both read buses and the mail override, because all of them come from the same input register.

The driver applies one stimulus set on a falling edge and queues its expected flag and read words. The monitor takes that entry two time units after the next rising edge and compares all three fields, so every comparison falls in the cycle the stimulus is due. The reset state is read directly while reset is held.

// File: rtl/lp_pkg.sv
package lp_pkg;

    localparam int BYTE_W     = 9;
    localparam int DATA_W     = BYTE_W - 1;
    localparam int NAR_LANES  = 2;
    localparam int WIDE_LANES = 4;
    localparam int NAR_W      = NAR_LANES * BYTE_W;
    localparam int WIDE_W     = WIDE_LANES * BYTE_W;

    typedef enum logic [1:0] {
        SZ_BYTE      = 2'b00,
        SZ_WORD      = 2'b01,
        SZ_BYTE_ALT  = 2'b10,
        SZ_WORD_MAIL = 2'b11
    } size_e;

    typedef struct packed {
        logic              odd;
        size_e             size;
        logic              nar_wr;
        logic              nar_gen;
        logic              wide_gen;
        logic [NAR_W-1:0]  nar_din;
        logic [NAR_W-1:0]  nar_fifo;
        logic [NAR_W-1:0]  mail;
        logic [WIDE_W-1:0] wide_in;
    } stage_t;

    // Parity bit that completes a lane whose payload XOR is dx.
    function automatic logic fill_bit(input logic dx, input logic odd);
        return dx ^ odd;
    endfunction

    // Lane is wrong when payload XOR, stored bit and sense do not agree.
    function automatic logic lane_bad(input logic dx, input logic p, input logic odd);
        return dx ^ p ^ odd;
    endfunction

    function automatic logic size_is_word(input size_e s);
        return (s == SZ_WORD) || (s == SZ_WORD_MAIL);
    endfunction

    // Mask of payload bits across the wide bus.
    function automatic logic [WIDE_W-1:0] wide_payload_mask();
        logic [WIDE_W-1:0] m;
        m = '0;
        for (int i = 0; i < WIDE_LANES; i++) begin
            m[i*BYTE_W +: DATA_W] = '1;
        end
        return m;
    endfunction

endpackage

// File: rtl/lp_capture.sv
module lp_capture
    import lp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  stage_t d,
    output stage_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/lp_xor_tree.sv
module lp_xor_tree
    import lp_pkg::*;
#(
    parameter int LANES = NAR_LANES
) (
    input  logic [LANES*BYTE_W-1:0] bytes_i,
    output logic [LANES-1:0]        dx_o
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign dx_o[i] = ^bytes_i[i*BYTE_W +: DATA_W];
    end

endmodule

// File: rtl/lp_lane_fill.sv
module lp_lane_fill
    import lp_pkg::*;
#(
    parameter int LANES = NAR_LANES
) (
    input  logic [LANES*BYTE_W-1:0] data_i,
    input  logic [LANES-1:0]        dx_i,
    input  logic                    gen_i,
    input  logic                    odd_i,
    output logic [LANES*BYTE_W-1:0] data_o
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign data_o[i*BYTE_W +: DATA_W] = data_i[i*BYTE_W +: DATA_W];
        assign data_o[i*BYTE_W + DATA_W]  = gen_i ? fill_bit(dx_i[i], odd_i)
                                                  : data_i[i*BYTE_W + DATA_W];
    end

endmodule

// File: rtl/lp_narrow_check.sv
module lp_narrow_check
    import lp_pkg::*;
(
    input  logic [NAR_LANES-1:0] dx_i,
    input  logic [NAR_LANES-1:0] par_i,
    input  logic                 odd_i,
    input  logic                 word_i,
    input  logic                 force_i,
    output logic                 perr_n_o
);

    logic [NAR_LANES-1:0] in_use;
    logic [NAR_LANES-1:0] bad;

    for (genvar i = 0; i < NAR_LANES; i++) begin : g_lane
        if (i == 0) begin : g_low
            assign in_use[i] = 1'b1;
        end else begin : g_up
            assign in_use[i] = word_i;
        end
        assign bad[i] = in_use[i] & lane_bad(dx_i[i], par_i[i], odd_i);
    end

    assign perr_n_o = force_i | ~(|bad);

endmodule

// File: rtl/lane_parity_unit.sv
module lane_parity_unit
    import lp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              odd_sel,
    input  logic [1:0]        size_sel,
    input  logic              nar_wr_en,
    input  logic              nar_gen_en,
    input  logic              wide_gen_en,
    input  logic [NAR_W-1:0]  nar_din,
    input  logic [NAR_W-1:0]  nar_fifo_q,
    input  logic [NAR_W-1:0]  mail_q,
    input  logic [WIDE_W-1:0] wide_fifo_q,
    output logic              nar_perr_n,
    output logic [NAR_W-1:0]  nar_rd_q,
    output logic [WIDE_W-1:0] wide_rd_q
);

    stage_t st_d;
    stage_t st;

    always_comb begin
        st_d          = '0;
        st_d.odd      = odd_sel;
        st_d.size     = size_e'(size_sel);
        st_d.nar_wr   = nar_wr_en;
        st_d.nar_gen  = nar_gen_en;
        st_d.wide_gen = wide_gen_en;
        st_d.nar_din  = nar_din;
        st_d.nar_fifo = nar_fifo_q;
        st_d.mail     = mail_q;
        st_d.wide_in  = wide_fifo_q;
    end

    lp_capture u_cap (
        .clk (clk),
        .rst (rst),
        .d   (st_d),
        .q   (st)
    );

    logic mail_sel;
    logic mail_gen;
    assign mail_sel = !st.nar_wr && (st.size == SZ_WORD_MAIL);
    assign mail_gen = mail_sel && st.nar_gen;

    // The narrow check trees are lent to the mail path when it generates.
    logic [NAR_W-1:0]     shared_in;
    logic [NAR_LANES-1:0] shared_dx;
    assign shared_in = mail_gen ? st.mail : st.nar_din;

    lp_xor_tree #(.LANES(NAR_LANES)) u_shared_tree (
        .bytes_i (shared_in),
        .dx_o    (shared_dx)
    );

    logic [NAR_LANES-1:0] fifo_dx;
    lp_xor_tree #(.LANES(NAR_LANES)) u_fifo_tree (
        .bytes_i (st.nar_fifo),
        .dx_o    (fifo_dx)
    );

    logic [WIDE_LANES-1:0] wide_dx;
    lp_xor_tree #(.LANES(WIDE_LANES)) u_wide_tree (
        .bytes_i (st.wide_in),
        .dx_o    (wide_dx)
    );

    lp_lane_fill #(.LANES(WIDE_LANES)) u_wide_fill (
        .data_i (st.wide_in),
        .dx_i   (wide_dx),
        .gen_i  (st.wide_gen),
        .odd_i  (st.odd),
        .data_o (wide_rd_q)
    );

    logic [NAR_W-1:0] fifo_out;
    logic [NAR_W-1:0] mail_out;

    lp_lane_fill #(.LANES(NAR_LANES)) u_fifo_fill (
        .data_i (st.nar_fifo),
        .dx_i   (fifo_dx),
        .gen_i  (st.nar_gen),
        .odd_i  (st.odd),
        .data_o (fifo_out)
    );

    lp_lane_fill #(.LANES(NAR_LANES)) u_mail_fill (
        .data_i (st.mail),
        .dx_i   (shared_dx),
        .gen_i  (mail_gen),
        .odd_i  (st.odd),
        .data_o (mail_out)
    );

    assign nar_rd_q = mail_sel ? mail_out : fifo_out;

    logic [NAR_LANES-1:0] nar_par;
    for (genvar i = 0; i < NAR_LANES; i++) begin : g_par
        assign nar_par[i] = st.nar_din[i*BYTE_W + DATA_W];
    end

    lp_narrow_check u_check (
        .dx_i     (shared_dx),
        .par_i    (nar_par),
        .odd_i    (st.odd),
        .word_i   (size_is_word(st.size)),
        .force_i  (mail_gen),
        .perr_n_o (nar_perr_n)
    );

    // Marks that a full input cycle has been captured since reset.
    logic primed;
    always_ff @(posedge clk) begin
        if (rst) begin
            primed <= 1'b0;
        end else begin
            primed <= 1'b1;
        end
    end

    // R7
    mail_force_chk: assert property (@(posedge clk) disable iff (rst || !primed)
        $past(!nar_wr_en && (size_sel == 2'b11) && nar_gen_en) |-> nar_perr_n)
        else $error("mail read with generation must hold the error flag inactive");

    // R2
    low_lane_bad_chk: assert property (@(posedge clk) disable iff (rst || !primed)
        $past(!(!nar_wr_en && (size_sel == 2'b11) && nar_gen_en)
              && ((^nar_din[BYTE_W-1:0]) != odd_sel)) |-> !nar_perr_n)
        else $error("wrong low lane must pull the error flag low");

    // R3
    byte_mode_upper_ignored_chk: assert property (@(posedge clk) disable iff (rst || !primed)
        $past(!size_sel[0] && ((^nar_din[BYTE_W-1:0]) == odd_sel)) |-> nar_perr_n)
        else $error("upper lane must be ignored in byte width");

    // R5
    wide_pass_chk: assert property (@(posedge clk) disable iff (rst || !primed)
        $past(!wide_gen_en) |-> (wide_rd_q == $past(wide_fifo_q)))
        else $error("wide read must pass through without generation");

    // R5
    wide_payload_keep_chk: assert property (@(posedge clk) disable iff (rst || !primed)
        1'b1 |-> ((wide_rd_q & wide_payload_mask()) == ($past(wide_fifo_q) & wide_payload_mask())))
        else $error("wide payload bits must never change");

    // R6
    nar_fifo_gen_chk: assert property (@(posedge clk) disable iff (rst || !primed)
        $past(nar_gen_en && !(!nar_wr_en && (size_sel == 2'b11)))
        |-> ((^nar_rd_q[BYTE_W-1:0]) == $past(odd_sel)))
        else $error("generated narrow low lane has wrong parity");

endmodule

// File: tb/lane_parity_unit_test.sv
module lane_parity_unit_test;

    localparam int BW = 9;
    localparam int NW = 18;
    localparam int WW = 36;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          odd_sel = 1'b0;
    logic [1:0]    size_sel = 2'b00;
    logic          nar_wr_en = 1'b0;
    logic          nar_gen_en = 1'b0;
    logic          wide_gen_en = 1'b0;
    logic [NW-1:0] nar_din = '0;
    logic [NW-1:0] nar_fifo_q = '0;
    logic [NW-1:0] mail_q = '0;
    logic [WW-1:0] wide_fifo_q = '0;
    logic          nar_perr_n;
    logic [NW-1:0] nar_rd_q;
    logic [WW-1:0] wide_rd_q;

    always #10 clk = ~clk;

    lane_parity_unit uut (
        .clk         (clk),
        .rst         (rst),
        .odd_sel     (odd_sel),
        .size_sel    (size_sel),
        .nar_wr_en   (nar_wr_en),
        .nar_gen_en  (nar_gen_en),
        .wide_gen_en (wide_gen_en),
        .nar_din     (nar_din),
        .nar_fifo_q  (nar_fifo_q),
        .mail_q      (mail_q),
        .wide_fifo_q (wide_fifo_q),
        .nar_perr_n  (nar_perr_n),
        .nar_rd_q    (nar_rd_q),
        .wide_rd_q   (wide_rd_q)
    );

    typedef struct {
        logic          flag;
        logic [NW-1:0] nar;
        logic [WW-1:0] wide;
        string         tag;
    } exp_t;

    exp_t sb[$];
    int total = 0;
    int bad = 0;

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [WW-1:0] act, input logic [WW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // Parity bit that completes payload d under the chosen sense.
    function automatic logic want_bit(input logic [7:0] d, input logic odd);
        int ones = 0;
        for (int i = 0; i < 8; i++) ones += d[i];
        return ones[0] ^ odd;
    endfunction

    function automatic logic lane_wrong(input logic [8:0] b, input logic odd);
        int ones = 0;
        for (int i = 0; i < 9; i++) ones += b[i];
        return ones[0] != odd;
    endfunction

    function automatic logic [8:0] good9(input logic [7:0] d, input logic odd);
        return {want_bit(d, odd), d};
    endfunction

    function automatic logic [8:0] bad9(input logic [7:0] d, input logic odd);
        return {~want_bit(d, odd), d};
    endfunction

    function automatic logic [NW-1:0] regen18(input logic [NW-1:0] v, input logic odd);
        logic [NW-1:0] r = v;
        for (int k = 0; k < 2; k++) r[k*BW+8] = want_bit(v[k*BW +: 8], odd);
        return r;
    endfunction

    function automatic logic [WW-1:0] regen36(input logic [WW-1:0] v, input logic odd);
        logic [WW-1:0] r = v;
        for (int k = 0; k < 4; k++) r[k*BW+8] = want_bit(v[k*BW +: 8], odd);
        return r;
    endfunction

    // Driver: present one stimulus on a falling edge and queue its expectation.
    task automatic step(input logic odd, input logic [1:0] sz, input logic wr,
                        input logic ng, input logic wg, input logic [NW-1:0] din,
                        input logic [NW-1:0] fq, input logic [NW-1:0] mq,
                        input logic [WW-1:0] wq, input string tag);
        exp_t e;
        logic msel, mgen, lowbad, upbad;
        @(negedge clk);
        odd_sel = odd; size_sel = sz; nar_wr_en = wr; nar_gen_en = ng;
        wide_gen_en = wg; nar_din = din; nar_fifo_q = fq; mail_q = mq;
        wide_fifo_q = wq;
        msel   = !wr && (sz == 2'b11);
        mgen   = msel && ng;
        lowbad = lane_wrong(din[8:0], odd);
        upbad  = sz[0] && lane_wrong(din[17:9], odd);
        e.flag = mgen ? 1'b1 : !(lowbad || upbad);
        if (msel) e.nar = ng ? regen18(mq, odd) : mq;
        else      e.nar = ng ? regen18(fq, odd) : fq;
        e.wide = wg ? regen36(wq, odd) : wq;
        e.tag  = tag;
        sb.push_back(e);
    endtask

    // Monitor: results are due right after the next rising edge.
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk(nar_perr_n == e.flag, e.tag, "nar_perr_n", {35'd0, nar_perr_n}, {35'd0, e.flag});
            chk(nar_rd_q == e.nar, e.tag, "nar_rd_q", {18'd0, nar_rd_q}, {18'd0, e.nar});
            chk(wide_rd_q == e.wide, e.tag, "wide_rd_q", wide_rd_q, e.wide);
        end
    end

    initial begin
        #4000000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] a, b, c, d;
        a = 8'h5A; b = 8'h13; c = 8'hF0; d = 8'h01;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(nar_perr_n == 1'b1, "R1", "nar_perr_n", {35'd0, nar_perr_n}, 36'd1);
        chk(nar_rd_q == '0, "R1", "nar_rd_q", {18'd0, nar_rd_q}, 36'd0);
        chk(wide_rd_q == '0, "R1", "wide_rd_q", wide_rd_q, 36'd0);
        rst = 1'b0;
        @(negedge clk);

        // R2/R9: clean word, then wrong low lane in byte width
        step(1'b0, 2'b01, 1'b1, 1'b0, 1'b0, {good9(a,0), good9(b,0)}, '0, '0, '0, "R2");
        step(1'b0, 2'b00, 1'b1, 1'b0, 1'b0, {good9(a,0), bad9(b,0)},  '0, '0, '0, "R2");
        step(1'b0, 2'b01, 1'b1, 1'b0, 1'b0, {good9(a,0), good9(b,0)}, '0, '0, '0, "R9");
        // R3: upper lane ignored in byte width, checked in word width
        step(1'b0, 2'b00, 1'b1, 1'b0, 1'b0, {bad9(a,0), good9(b,0)}, '0, '0, '0, "R3");
        step(1'b0, 2'b10, 1'b1, 1'b0, 1'b0, {bad9(a,0), good9(b,0)}, '0, '0, '0, "R3");
        step(1'b0, 2'b01, 1'b1, 1'b0, 1'b0, {bad9(a,0), good9(b,0)}, '0, '0, '0, "R3");
        // R4: same bytes under the opposite sense
        step(1'b1, 2'b01, 1'b1, 1'b0, 1'b0, {good9(a,0), good9(b,0)}, '0, '0, '0, "R4");
        step(1'b1, 2'b01, 1'b1, 1'b0, 1'b0, {good9(a,1), good9(b,1)}, '0, '0, '0, "R4");
        // R5: wide generation both senses and passthrough
        step(1'b0, 2'b01, 1'b1, 1'b0, 1'b1, '0, '0, '0, 36'hF_FFFF_FFFF, "R5");
        step(1'b1, 2'b01, 1'b1, 1'b0, 1'b1, '0, '0, '0, {1'b0,c,1'b1,d,1'b0,a,1'b1,b}, "R5");
        step(1'b1, 2'b01, 1'b1, 1'b0, 1'b0, '0, '0, '0, {1'b0,c,1'b1,d,1'b0,a,1'b1,b}, "R5");
        // R6: narrow queue read with and without generation
        step(1'b0, 2'b01, 1'b1, 1'b1, 1'b0, '0, {1'b1,c,1'b1,d}, 18'h3FFFF, '0, "R6");
        step(1'b1, 2'b00, 1'b0, 1'b1, 1'b0, '0, {1'b0,a,1'b0,b}, 18'h3FFFF, '0, "R6");
        step(1'b1, 2'b00, 1'b0, 1'b0, 1'b0, '0, {1'b0,a,1'b0,b}, 18'h3FFFF, '0, "R6");
        // R7: mail read with generation forces the flag despite wrong input
        step(1'b0, 2'b11, 1'b0, 1'b1, 1'b0, {bad9(a,0), bad9(b,0)}, 18'h00F0F, {1'b0,c,1'b0,d}, '0, "R7");
        step(1'b1, 2'b11, 1'b0, 1'b1, 1'b0, {bad9(a,1), bad9(b,1)}, 18'h00F0F, {1'b1,a,1'b1,b}, '0, "R7");
        // R8: mail read without generation, and write high with size 11
        step(1'b0, 2'b11, 1'b0, 1'b0, 1'b0, {good9(a,0), bad9(b,0)}, 18'h00F0F, {1'b1,c,1'b0,d}, '0, "R8");
        step(1'b0, 2'b11, 1'b1, 1'b1, 1'b0, {bad9(a,0), good9(b,0)}, {1'b0,c,1'b0,d}, 18'h2AAAA, '0, "R8");

        // Mixed patterns across all modes
        for (int n = 0; n < 60; n++) begin
            logic [NW-1:0] r1, r2, r3;
            logic [WW-1:0] r4;
            logic [5:0] ctl;
            r1 = NW'($urandom); r2 = NW'($urandom); r3 = NW'($urandom);
            r4 = {4'($urandom), 32'($urandom)};
            ctl = 6'($urandom);
            step(ctl[0], ctl[2:1], ctl[3], ctl[4], ctl[5], r1, r2, r3, r4, "R9");
        end

        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule